// File: doc/BRIEF.md
# Accumulator Pointer Control Unit

This block keeps the 4-bit pointer that selects one of sixteen working accumulators. It drives the accumulator-file select lines directly. Software reaches two 8-bit registers through a simple register bus: a pointer register and a stepping-control register. Each register has its own write strobe, and the two share one write-data bus. Each register returns its contents on a read-data output of its own.

The stepping-control register can make the pointer move by itself. After every completed arithmetic or logical operation, which the datapath signals with a one-cycle pulse, the pointer counts up or down. The count wraps inside an aligned window of 2, 4, 8 or 16 accumulators. The control register also has a self-clearing clear command that returns the pointer to zero.

Fixed priorities settle collisions in a single cycle. A clear command wins over everything else. An enabled auto-step wins over a direct pointer write.

Top module: `acc_ptr_unit`

## Requirements
- R1: While reset is asserted, and at the first sampling point after it is released, `acc_sel` is 0 and both read-data outputs are 00h.
- R2: A pointer write (`ptr_wr`) with no clear and no enabled step loads `wdata[3:0]` into the pointer. The new value appears on `acc_sel` and on `ptr_rd_data[3:0]` one clock later. `wdata[7:4]` is ignored, and `ptr_rd_data[7:4]` always reads 0.
- R3: A control write (`ctl_wr`) stores `wdata[6]` as the step direction (0 = up, 1 = down) and `wdata[2:0]` as the step mode. `ctl_rd_data` returns them in the same bit positions, with bit 7 and bits 5:3 read as 0.
- R4: With mode 000, an operation pulse leaves the pointer unchanged for either direction. A pointer write in the same cycle is then applied.
- R5: With direction 0, a pulse adds 1 to the low N pointer bits modulo 2^N and leaves the upper bits unchanged. N is 1, 2, 3 and 4 for modes 001, 010, 011 and 100.
- R6: With direction 1, a pulse subtracts 1 from the low N pointer bits in the same way. For example, 4 in mode 010 becomes 7.
- R7: Modes 101, 110 and 111 step exactly as mode 100 does.
- R8: When an enabled step and a pointer write fall in the same cycle, the pointer takes the stepped value and the written data is discarded.
- R9: A control write with `wdata[7]` = 1 sets the pointer to 0 one clock later. This overrides a simultaneous step and a simultaneous pointer write. Bit 7 is not stored.
- R10: A control write takes effect from the next operation pulse. A pulse in the same cycle as the control write steps with the previous direction and mode.
- R11: With no write strobe and no operation pulse, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| ptr_wr | input | 1 | Write strobe for the pointer register |
| ctl_wr | input | 1 | Write strobe for the stepping-control register |
| wdata | input | 8 | Write data shared by both registers |
| alu_done | input | 1 | One-cycle pulse per completed arithmetic/logical operation |
| ptr_rd_data | output | 8 | Pointer register read value |
| ctl_rd_data | output | 8 | Control register read value |
| acc_sel | output | 4 | Current pointer, accumulator select |

## Verification
Every pointer result (a write, a step, a clear, or a collision between them) passes through one register. It is therefore due exactly one clock after the cycle in which the stimulus is presented. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge. Control read-back is also due one clock after its write. When the control write and a step collide, the same-cycle step is checked at one clock, and the next pulse is checked one clock after it is presented. After reset is released, the bench waits three clocks for the two-stage release synchronizer before it presents any stimulus.

// File: rtl/apcu_pkg.sv
package apcu_pkg;

  // Bit positions that the control register decodes
  localparam int CLR_BIT = 7;
  localparam int DIR_BIT = 6;
  localparam int MODE_W  = 3;

  typedef struct packed {
    logic              dir;   // 0: count up, 1: count down
    logic [MODE_W-1:0] mode;  // 0: no stepping, k: window of 2^k
  } step_cfg_t;

endpackage

// File: rtl/apcu_rst_sync.sv
module apcu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/apcu_ctl_reg.sv
module apcu_ctl_reg
  import apcu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output step_cfg_t         cfg,
  output logic              clr_req,
  output logic [DATA_W-1:0] rd_data
);

  // Only the direction bit and the mode field are kept; the rest are
  // reserved or self-clearing and never reach storage.
  localparam logic [DATA_W-1:0] KEEP_MASK =
    DATA_W'((1 << DIR_BIT) | ((1 << MODE_W) - 1));

  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] ctl_d;
  logic              ctl_en;

  always_comb begin
    ctl_en = wr_en;
    ctl_d  = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  assign clr_req  = wr_en & wdata[CLR_BIT];
  assign cfg.dir  = ctl_q[DIR_BIT];
  assign cfg.mode = ctl_q[MODE_W-1:0];
  assign rd_data  = ctl_q;

endmodule

// File: rtl/apcu_stepper.sv
module apcu_stepper
  import apcu_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic [PTR_W-1:0] ptr_in,
  input  step_cfg_t        cfg,
  output logic             step_en,
  output logic [PTR_W-1:0] ptr_out
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] win_mask;
  logic [PTR_W-1:0] moved;
  int               win_bits;

  always_comb begin
    // Window width in bits; modes beyond the pointer width use the whole pointer
    win_bits = (int'(cfg.mode) > PTR_W) ? PTR_W : int'(cfg.mode);
  end

  for (genvar gi = 0; gi < PTR_W; gi++) begin : g_mask
    assign win_mask[gi] = (gi < win_bits);
  end

  always_comb begin
    moved   = cfg.dir ? (ptr_in - ONE) : (ptr_in + ONE);
    ptr_out = (ptr_in & ~win_mask) | (moved & win_mask);
    step_en = (cfg.mode != '0);
  end

endmodule

// File: rtl/acc_ptr_unit.sv
module acc_ptr_unit
  import apcu_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              alu_done,
  output logic [DATA_W-1:0] ptr_rd_data,
  output logic [DATA_W-1:0] ctl_rd_data,
  output logic [PTR_W-1:0]  acc_sel
);

  logic             rst_core_n;
  step_cfg_t        cfg;
  logic             clr_req;
  logic             step_en;
  logic [PTR_W-1:0] stepped;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  apcu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  apcu_ctl_reg #(.DATA_W(DATA_W)) u_ctl_reg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (ctl_wr),
    .wdata   (wdata),
    .cfg     (cfg),
    .clr_req (clr_req),
    .rd_data (ctl_rd_data)
  );

  // Steps with the stored settings, so a same-cycle control write is not yet seen
  apcu_stepper #(.PTR_W(PTR_W)) u_stepper (
    .ptr_in  (ptr_q),
    .cfg     (cfg),
    .step_en (step_en),
    .ptr_out (stepped)
  );

  // Priority: clear > enabled step > direct write > hold
  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (clr_req) begin
      ptr_d  = '0;
      ptr_en = 1'b1;
    end else if (alu_done && step_en) begin
      ptr_d  = stepped;
      ptr_en = 1'b1;
    end else if (ptr_wr) begin
      ptr_d  = wdata[PTR_W-1:0];
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign acc_sel     = ptr_q;
  assign ptr_rd_data = DATA_W'(ptr_q);

endmodule

// File: rtl/apcu_checker.sv
module apcu_checker #(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              ptr_wr,
  input logic              ctl_wr,
  input logic [DATA_W-1:0] wdata,
  input logic              alu_done,
  input logic [DATA_W-1:0] ctl_rd_data,
  input logic [PTR_W-1:0]  acc_sel
);

  // R9: clear command zeroes the pointer whatever else happens
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctl_wr && wdata[7]) |=> (acc_sel == '0));

  // R11: no activity, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ctl_wr && !ptr_wr && !alu_done) |=> $stable(acc_sel));

  // R2: plain pointer write
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ptr_wr && !ctl_wr && !alu_done) |=> (acc_sel == $past(wdata[PTR_W-1:0])));

  // R4: mode 0 suppresses stepping
  a_r4_mode_off: assert property (@(posedge clk) disable iff (!rst_core_n)
    (alu_done && ctl_rd_data[2:0] == 3'd0 && !ptr_wr && !ctl_wr) |=> $stable(acc_sel));

  // R5/R7/R8: full-window increment, even against a pointer write
  a_r5_full_inc: assert property (@(posedge clk) disable iff (!rst_core_n)
    (alu_done && ctl_rd_data[2] && !ctl_rd_data[6] && !ctl_wr)
      |=> (acc_sel == PTR_W'($past(acc_sel) + 1'b1)));

  // R6: modulo-4 decrement keeps the upper bits
  a_r6_mod4_dec: assert property (@(posedge clk) disable iff (!rst_core_n)
    (alu_done && ctl_rd_data[2:0] == 3'd2 && ctl_rd_data[6] && !ctl_wr)
      |=> (acc_sel[1:0] == 2'($past(acc_sel[1:0]) - 2'd1)
           && acc_sel[PTR_W-1:2] == $past(acc_sel[PTR_W-1:2])));

  // R5: modulo-2 step toggles only bit 0
  a_r5_mod2_toggle: assert property (@(posedge clk) disable iff (!rst_core_n)
    (alu_done && ctl_rd_data[2:0] == 3'd1 && !ctl_wr)
      |=> (acc_sel[0] != $past(acc_sel[0])
           && acc_sel[PTR_W-1:1] == $past(acc_sel[PTR_W-1:1])));

endmodule

bind acc_ptr_unit apcu_checker #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_apcu_checker (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .ptr_wr      (ptr_wr),
  .ctl_wr      (ctl_wr),
  .wdata       (wdata),
  .alu_done    (alu_done),
  .ctl_rd_data (ctl_rd_data),
  .acc_sel     (acc_sel)
);

// File: tb/acc_ptr_unit_bench.sv
`timescale 1ns/1ps
module acc_ptr_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ptr_wr, ctl_wr, alu_done;
  logic [7:0] wdata;
  logic [7:0] ptr_rd_data, ctl_rd_data;
  logic [3:0] acc_sel;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  acc_ptr_unit u_acc_ptr_unit (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ctl_wr(ctl_wr),
    .wdata(wdata), .alu_done(alu_done), .ptr_rd_data(ptr_rd_data),
    .ctl_rd_data(ctl_rd_data), .acc_sel(acc_sel)
  );

  function automatic logic [3:0] exp_step(logic [3:0] p, logic [2:0] m, logic d);
    int         n;
    logic [3:0] msk, q;
    n   = (m > 3'd4) ? 4 : int'(m);
    msk = 4'((1 << n) - 1);
    q   = d ? p - 4'd1 : p + 4'd1;
    return (p & ~msk) | (q & msk);
  endfunction

  function automatic string sweep_tag(logic [2:0] m, logic d);
    if (m == 3'd0) return "R4";
    if (m > 3'd4)  return "R7";
    return d ? "R6" : "R5";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present inputs at a falling edge, pass one rising edge, return at the next falling edge
  task automatic apply(input logic pw, input logic cw, input logic ad, input logic [7:0] d);
    ptr_wr = pw; ctl_wr = cw; alu_done = ad; wdata = d;
    @(posedge clk);
    @(negedge clk);
    ptr_wr = 1'b0; ctl_wr = 1'b0; alu_done = 1'b0; wdata = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ptr_wr = 1'b0; ctl_wr = 1'b0; alu_done = 1'b0; wdata = 8'h00;
    repeat (2) @(negedge clk);
    chk("R1", {4'h0, acc_sel}, 8'h00);
    chk("R1", ptr_rd_data, 8'h00);
    chk("R1", ctl_rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", {4'h0, acc_sel}, 8'h00);

    // R2: every pointer value, with junk in the reserved bits
    for (int v = 0; v < 16; v++) begin
      apply(1'b1, 1'b0, 1'b0, {4'(15 - v), 4'(v)});
      chk("R2", {4'h0, acc_sel}, 8'(v));
      chk("R2", ptr_rd_data, 8'(v));
    end

    // R3 + R9: all-ones control write: stores dir and mode, clears pointer
    apply(1'b0, 1'b1, 1'b0, 8'hFF);
    chk("R3", ctl_rd_data, 8'h47);
    chk("R9", {4'h0, acc_sel}, 8'h00);
    apply(1'b0, 1'b1, 1'b0, 8'h38);
    chk("R3", ctl_rd_data, 8'h00);

    // R4..R7: sweep every mode, direction and start value
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 2; d++) begin
        apply(1'b0, 1'b1, 1'b0, {1'b0, 1'(d), 3'b000, 3'(m)});
        for (int p = 0; p < 16; p++) begin
          apply(1'b1, 1'b0, 1'b0, 8'(p));
          apply(1'b0, 1'b0, 1'b1, 8'h00);
          chk(sweep_tag(3'(m), 1'(d)), {4'h0, acc_sel},
              {4'h0, exp_step(4'(p), 3'(m), 1'(d))});
        end
      end
    end

    // R8: step beats pointer write
    apply(1'b0, 1'b1, 1'b0, 8'h04);
    apply(1'b1, 1'b0, 1'b0, 8'h03);
    apply(1'b1, 1'b0, 1'b1, 8'h09);
    chk("R8", {4'h0, acc_sel}, 8'h04);
    // R4: with stepping off the same collision applies the write
    apply(1'b0, 1'b1, 1'b0, 8'h40);
    apply(1'b1, 1'b0, 1'b1, 8'h09);
    chk("R4", {4'h0, acc_sel}, 8'h09);

    // R9: clear beats step and write; clear bit not stored
    apply(1'b0, 1'b1, 1'b0, 8'h04);
    apply(1'b1, 1'b0, 1'b0, 8'h06);
    apply(1'b1, 1'b1, 1'b1, 8'h84);
    chk("R9", {4'h0, acc_sel}, 8'h00);
    chk("R9", ctl_rd_data, 8'h04);
    apply(1'b0, 1'b0, 1'b1, 8'h00);
    chk("R9", {4'h0, acc_sel}, 8'h01);

    // R10: same-cycle pulse uses old settings, next pulse uses new
    apply(1'b1, 1'b0, 1'b0, 8'h08);
    apply(1'b0, 1'b1, 1'b1, 8'h41);
    chk("R10", {4'h0, acc_sel}, 8'h09);
    chk("R10", ctl_rd_data, 8'h41);
    apply(1'b0, 1'b0, 1'b1, 8'h00);
    chk("R10", {4'h0, acc_sel}, 8'h08);

    // R11: idle cycles hold the pointer
    apply(1'b1, 1'b0, 1'b0, 8'h0B);
    repeat (5) @(negedge clk);
    chk("R11", {4'h0, acc_sel}, 8'h0B);

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", {4'h0, acc_sel}, 8'h00);
    chk("R1", ctl_rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", ptr_rd_data, 8'h00);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule